// File: doc/BRIEF.md
# Remapped-Enable Interrupt Aggregator

This block collects 32 peripheral request lines into a sticky pending register and folds them onto one interrupt line towards a parent interrupt controller. Software reaches two registers through a small register port: the pending register, where writing ones acknowledges bits, and the enable register, which decides which pending bits may reach the output.

Each pending bit is qualified by an enable bit, but the enable bit does not have to sit at the same position. A per-variant routing table, fixed at elaboration, gives every pending position either an enable position, a "no enable" marking or a "reserved" marking. Positions without a usable route can pend but can never raise the output. Two variants are built in: a remapped one and a direct one where usable positions are enabled in place. Acknowledging a pending bit never masks it. Masking is done only through the enable register. The output is level style: it stays high while any enabled pending bit remains.

Top module: `intr_merge`

## Requirements
- R1: After a synchronous reset the pending register, the enable register, `reg_rdata` and `irq_out` are all zero.
- R2: A request line that is high at a rising clock edge sets its pending bit at that edge, and the bit stays set after the line drops.
- R3: A register write with `reg_sel`=0 clears every pending bit whose `reg_wdata` bit is 1 and leaves the bits written with 0 unchanged.
- R4: When a request line is high in the same cycle as a write-1 acknowledge of its bit, the bit stays set (set wins over clear).
- R5: A pending-register write never masks a source: an enabled source held high keeps `irq_out` high through any number of acknowledge writes.
- R6: A write with `reg_sel`=1 loads the whole enable register, and reading it returns exactly the written value, including bits no source uses. A read returns the register chosen by `reg_sel` one cycle later (0 pending, 1 enable).
- R7: In the remapped variant (VARIANT=VAR_REMAP) pending bit 8 is enabled by enable bit 7, pending bit 13 by enable bit 6, pending bit 23 by enable bit 28, and every other usable pending bit (3, 5, 10-12, 14, 15, 19-22, 24, 26, 27, 29) by the enable bit at its own position.
- R8: In the remapped variant pending positions 0, 1, 4, 16, 17, 18, 25, 28, 30 and 31 have no enable and never raise `irq_out`, whatever the enable register holds.
- R9: In the remapped variant the reserved pending positions 2, 6, 7 and 9 never raise `irq_out`.
- R10: `irq_out` is the registered OR of every usable pending bit ANDed with its routed enable bit; it follows the pending and enable registers one cycle later and stays high until the last enabled pending bit is acknowledged.
- R11: In the direct variant (VARIANT=VAR_DIRECT) the usable positions 2, 5, 8, 11, 12, 13, 19, 20, 29, 30 and 31 are each enabled by the enable bit at their own position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 32 | Peripheral request lines, one per pending bit |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data (ones acknowledge pending bits) |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq_out | output | 1 | Combined interrupt line to the parent controller |

## Verification
The two functions that can land on the same edge are the setting of a pending bit by a live request line and its clearing by a write-1 acknowledge. The bench holds a request line high while writing ones to its pending bit, then reads the pending register back and watches `irq_out` across repeated acknowledges: the bit must still be set and the line must not drop. Only after the request is released together with the acknowledge may the bit clear and the output fall one cycle later.

// File: rtl/intr_merge_pkg.sv
package intr_merge_pkg;

  localparam int unsigned SRC_N = 32;

  typedef enum logic [0:0] {
    VAR_REMAP  = 1'b0,
    VAR_DIRECT = 1'b1
  } variant_e;

  // Routing of one pending position to its enable bit.
  typedef struct packed {
    logic       live;    // position can reach the output
    logic       rsvd;    // position reserved
    logic [4:0] en_pos;  // enable bit position when live
  } route_t;

  function automatic route_t route_of(input variant_e v, input int unsigned s);
    route_t r;
    r.live   = 1'b0;
    r.rsvd   = 1'b0;
    r.en_pos = 5'(s);
    if (v == VAR_REMAP) begin
      case (s)
        2, 6, 7, 9:                          r.rsvd = 1'b1;
        0, 1, 4, 16, 17, 18, 25, 28, 30, 31: r.live = 1'b0;
        8:  begin r.live = 1'b1; r.en_pos = 5'd7;  end
        13: begin r.live = 1'b1; r.en_pos = 5'd6;  end
        23: begin r.live = 1'b1; r.en_pos = 5'd28; end
        default:                             r.live = 1'b1;
      endcase
    end else begin
      case (s)
        1, 7, 9, 21, 22, 23, 24:                                  r.rsvd = 1'b1;
        0, 3, 4, 6, 10, 14, 15, 16, 17, 18, 25, 26, 27, 28:       r.live = 1'b0;
        default:                                                  r.live = 1'b1;
      endcase
    end
    if (r.rsvd) r.live = 1'b0;
    return r;
  endfunction

  function automatic logic [SRC_N-1:0] live_mask(input variant_e v);
    logic [SRC_N-1:0] m;
    route_t r;
    for (int unsigned i = 0; i < SRC_N; i++) begin
      r    = route_of(v, i);
      m[i] = r.live;
    end
    return m;
  endfunction

endpackage

// File: rtl/intr_status_bank.sv
module intr_status_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic         ack_vld,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] clr_mask;

  always_comb begin
    clr_mask = ack_vld ? ack_bits : '0;
  end

  // Set has priority over a same-cycle acknowledge.
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | src;
  end

endmodule

// File: rtl/intr_enable_reg.sv
module intr_enable_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] en_q
);

  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wd;
  end

endmodule

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int unsigned              W       = 32,
  parameter intr_merge_pkg::variant_e VARIANT = intr_merge_pkg::VAR_REMAP
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  input  logic [W-1:0] en,
  output logic         irq_q
);
  import intr_merge_pkg::*;

  logic [W-1:0] hit;
  logic         unused_bits;

  generate
    for (genvar i = 0; i < W; i++) begin : g_route
      localparam route_t RT = route_of(VARIANT, i);
      if (RT.live) begin : g_live
        assign hit[i] = stat[i] & en[RT.en_pos];
      end else begin : g_dead
        assign hit[i] = 1'b0;
      end
    end
  endgenerate

  assign unused_bits = ^{stat, en};

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |hit;
  end

endmodule

// File: rtl/intr_merge.sv
module intr_merge #(
  parameter int unsigned              SRC_W   = intr_merge_pkg::SRC_N,
  parameter intr_merge_pkg::variant_e VARIANT = intr_merge_pkg::VAR_REMAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_req,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [SRC_W-1:0] reg_wdata,
  output logic [SRC_W-1:0] reg_rdata,
  output logic             irq_out
);

  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] en_q;
  logic             ack_vld;
  logic             en_we;

  assign ack_vld = reg_wr & ~reg_sel;
  assign en_we   = reg_wr &  reg_sel;

  intr_status_bank #(.W(SRC_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .src      (src_req),
    .ack_vld  (ack_vld),
    .ack_bits (reg_wdata),
    .stat_q   (stat_q)
  );

  intr_enable_reg #(.W(SRC_W)) u_en (
    .clk  (clk),
    .rst  (rst),
    .we   (en_we),
    .wd   (reg_wdata),
    .en_q (en_q)
  );

  intr_gate #(.W(SRC_W), .VARIANT(VARIANT)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat_q),
    .en    (en_q),
    .irq_q (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_sel ? en_q : stat_q;
  end

endmodule

// File: rtl/intr_merge_chk.sv
module intr_merge_chk #(
  parameter int unsigned              W       = 32,
  parameter intr_merge_pkg::variant_e VARIANT = intr_merge_pkg::VAR_REMAP
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] src_req,
  input logic         reg_sel,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic         irq_out,
  input logic [W-1:0] stat_q,
  input logic [W-1:0] en_q
);
  localparam logic [W-1:0] LIVE = intr_merge_pkg::live_mask(VARIANT);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (stat_q == '0 && en_q == '0 && !irq_out));

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    (src_req != '0) |=> ((stat_q & $past(src_req)) == $past(src_req)));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && !reg_sel) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_set_beats_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !reg_sel && ((src_req & reg_wdata) != '0))
      |=> ((stat_q & $past(src_req & reg_wdata)) == $past(src_req & reg_wdata)));

  p_en_load_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel) |=> (en_q == $past(reg_wdata)));

  p_en_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_sel) |=> $stable(en_q));

  // R8 and R9: positions without a usable route never drive the line.
  p_unreachable_r8: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & LIVE) == '0) |=> !irq_out);

endmodule

bind intr_merge intr_merge_chk #(.W(SRC_W), .VARIANT(VARIANT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .src_req   (src_req),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .irq_out   (irq_out),
  .stat_q    (stat_q),
  .en_q      (en_q)
);

// File: tb/sim_intr_merge.sv
`timescale 1ns/1ps
module sim_intr_merge;
  import intr_merge_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_req = '0;
  logic [31:0] src1 = '0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, rdata1;
  logic        irq_out, irq1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  intr_merge #(.SRC_W(32), .VARIANT(VAR_REMAP)) u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  intr_merge #(.SRC_W(32), .VARIANT(VAR_DIRECT)) u1 (
    .clk(clk), .rst(rst), .src_req(src1), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata1), .irq_out(irq1));

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    step(2);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [31:0] bits);
    src_req = bits;
    step();
    src_req = '0;
  endtask

  task automatic clean();
    wr(1'b1, '0);
    wr(1'b0, '1);
    step(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    rd(1'b0, d); check("R1 pending", d, 32'd0);
    rd(1'b1, d); check("R1 enable", d, 32'd0);
  endtask

  task automatic t_set_sticky();
    logic [31:0] d;
    pulse(32'h0000_0020);
    step(2);
    rd(1'b0, d); check("R2 sticky pending", d, 32'h0000_0020);
    check("R2 irq off while disabled", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    pulse(32'h0000_0420);
    wr(1'b0, 32'h0000_0000);
    rd(1'b0, d); check("R3 write zero keeps", d, 32'h0000_0420);
    wr(1'b0, 32'h0000_0020);
    rd(1'b0, d); check("R3 write one clears", d, 32'h0000_0400);
    clean();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    src_req = 32'h0000_1000;
    step();
    reg_sel = 1'b0; reg_wdata = 32'h0000_1000; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0; src_req = '0;
    rd(1'b0, d); check("R4 set beats ack", d, 32'h0000_1000);
    clean();
  endtask

  task automatic t_no_mask();
    wr(1'b1, 32'h0000_1000);
    src_req = 32'h0000_1000;
    step(2);
    check("R5 irq up", {31'd0, irq_out}, 32'd1);
    for (int k = 0; k < 3; k++) begin
      reg_sel = 1'b0; reg_wdata = '1; reg_wr = 1'b1;
      step();
      check("R5 irq held through ack", {31'd0, irq_out}, 32'd1);
    end
    src_req = '0; reg_wdata = 32'h0000_1000;
    step();
    reg_wr = 1'b0;
    step();
    check("R5 irq drops after release", {31'd0, irq_out}, 32'd0);
    clean();
  endtask

  task automatic t_enable_rb();
    logic [31:0] d;
    wr(1'b1, 32'hA5A5_F00F);
    rd(1'b1, d); check("R6 enable readback", d, 32'hA5A5_F00F);
    clean();
  endtask

  task automatic t_remap_one(input int s, input int e);
    wr(1'b1, 32'(1) << e);
    pulse(32'(1) << s);
    step();
    check($sformatf("R7 pend %0d via en %0d", s, e), {31'd0, irq_out}, 32'd1);
    clean();
    if (s != e) begin
      wr(1'b1, 32'(1) << s);
      pulse(32'(1) << s);
      step();
      check($sformatf("R7 pend %0d not via en %0d", s, s), {31'd0, irq_out}, 32'd0);
      clean();
    end
  endtask

  task automatic t_dead(input string req, input logic [31:0] mask);
    logic [31:0] d;
    wr(1'b1, '1);
    pulse(mask);
    for (int k = 0; k < 3; k++) begin
      check({req, " irq stays low"}, {31'd0, irq_out}, 32'd0);
      step();
    end
    rd(1'b0, d); check({req, " bits pend"}, d, mask);
    clean();
  endtask

  task automatic t_level();
    wr(1'b1, '1);
    pulse(32'h0000_0420);
    step();
    check("R10 irq high", {31'd0, irq_out}, 32'd1);
    wr(1'b0, 32'h0000_0020);
    step();
    check("R10 one left keeps high", {31'd0, irq_out}, 32'd1);
    wr(1'b0, 32'h0000_0400);
    check("R10 registered lag", {31'd0, irq_out}, 32'd1);
    step();
    check("R10 last ack drops", {31'd0, irq_out}, 32'd0);
    clean();
  endtask

  task automatic t_direct();
    wr(1'b1, 32'h0000_0100);
    src1 = 32'h0000_0100; step(); src1 = '0;
    step();
    check("R11 direct pend 8 via en 8", {31'd0, irq1}, 32'd1);
    clean();
    wr(1'b1, 32'h0000_0080);
    src1 = 32'h0000_0100; step(); src1 = '0;
    step();
    check("R11 direct pend 8 not via en 7", {31'd0, irq1}, 32'd0);
    clean();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_set_sticky();
    clean();
    t_ack();
    t_set_wins();
    t_no_mask();
    t_enable_rb();
    t_remap_one(8, 7);
    t_remap_one(13, 6);
    t_remap_one(23, 28);
    t_remap_one(3, 3);
    t_remap_one(21, 21);
    t_dead("R8", 32'hD207_0013);
    t_dead("R9", 32'h0000_02C4);
    t_level();
    t_direct();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule